// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Capture Buffer

This block sits between a capture engine and a processor-side reader that run on unrelated clocks. Storage is split into two equal banks. The write side fills one bank with a complete capture. It then signals completion with a single-cycle pulse, and its bank pointer flips so that the next capture lands in the other bank. The read side always reads the bank that was completed last, through a plain synchronous port with one cycle of latency.

The write-side bank bit is itself the crossing signal. Each completion toggles it, and the read domain passes it through a short synchronizer chain. A change seen at the end of the chain is a swap event. On that event the read-side bank select moves to the bank that was just completed, and a ready flag rises. The reader clears the flag with an acknowledge. A completion that arrives while the flag is still pending sets a sticky overflow indication, and the reader still moves to the newest bank. The default bank depth is reduced so the model stays small, and it can be raised to 4096 words per bank.

Top module: `pingpong_cdc_buffer`

## Requirements
- R1: After reset the write-side bank output `wr_bank` is 0. A write with `wr_en` high stores `wr_data` at word `wr_addr` of bank `wr_bank`. The bank does not change without a completion pulse.
- R2: A `wr_done` pulse flips `wr_bank` at the next write-clock edge. A write issued in the same cycle as `wr_done` still lands in the bank that is being completed.
- R3: While its reset is asserted, the read side shows `rd_bank` = 1, `rd_ready` = 0, `rd_overflow` = 0 and `rd_data` = 0.
- R4: After a completion, `rd_bank` takes the value of the bank just completed within 2 to 4 read-clock edges. It changes at no other time.
- R5: `rd_ready` rises in the same read-clock cycle that `rd_bank` updates. It stays high until `rd_ack` is sampled high, and then it returns to 0.
- R6: `rd_data` presents the word at `rd_addr` of bank `rd_bank` one read-clock edge after the address is applied. Until that edge it holds its previous value.
- R7: A completion that reaches the read side while `rd_ready` is high and not being acknowledged sets `rd_overflow`. This bit stays high until read-side reset. `rd_bank` still moves to the newest completed bank, and `rd_ready` stays high.
- R8: Writes to the bank the writer owns never alter the data the reader obtains from the bank it holds.
- R9: An `rd_ack` given while `rd_ready` is low changes neither `rd_ready`, `rd_overflow` nor `rd_bank`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address within the write bank |
| wr_data | input | DATA_W | Word to store |
| wr_done | input | 1 | Single-cycle capture-complete pulse |
| wr_bank | output | 1 | Bank currently owned by the writer |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous active-low reset |
| rd_addr | input | ADDR_W | Word address within the read bank |
| rd_ack | input | 1 | Acknowledge of a handed-over bank |
| rd_data | output | DATA_W | Registered read word |
| rd_bank | output | 1 | Bank select seen by the reader |
| rd_ready | output | 1 | A newly completed bank is waiting |
| rd_overflow | output | 1 | Sticky: a bank was handed over before the previous one was acknowledged |

## Verification
The bench writes into the bank it owns while the reader holds the other bank, and then confirms that the reader's words are unchanged. A design that decoded the bank bit wrongly on either port would show the writer's fresh data there. The bench also places a write in the same cycle as the completion pulse. A writer that flipped its bank a cycle early would store that word in the wrong bank. It counts read-clock edges from completion to the bank change, which exposes a missing or extra synchronizer stage. A second completion is issued without an acknowledge, which catches a design that drops the newest bank, clears the overflow bit, or lets ready fall.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    BANK_PING = 1'b0,
    BANK_PONG = 1'b1
  } bank_e;
endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = stage_q[STAGES-1];
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  output logic bank_o
);
  import pp_pkg::*;

  bank_e bank_q, bank_d;

  always_comb begin
    bank_d = bank_q;
    if (done_i) bank_d = bank_e'(~bank_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= BANK_PING;
    else        bank_q <= bank_d;
  end

  assign bank_o = bank_q;

  assert_flip_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (bank_o != $past(bank_o)));
  assert_hold_without_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(bank_o));
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wbank_async,
  input  logic ack_i,
  output logic bank_o,
  output logic ready_o,
  output logic ovf_o
);
  logic [SYNC_STAGES:0] chain_q, chain_d;
  logic                 bank_q, bank_d;
  logic                 rdy_q, rdy_d;
  logic                 ovf_q, ovf_d;
  logic                 swap_evt;

  always_comb begin
    chain_d  = {chain_q[SYNC_STAGES-1:0], wbank_async};
    swap_evt = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];
    bank_d   = bank_q;
    rdy_d    = rdy_q;
    ovf_d    = ovf_q;
    if (swap_evt) begin
      bank_d = ~chain_q[SYNC_STAGES-1];
      rdy_d  = 1'b1;
      if (rdy_q && !ack_i) ovf_d = 1'b1;
    end else if (ack_i) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      bank_q  <= 1'b1;
      rdy_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      chain_q <= chain_d;
      bank_q  <= bank_d;
      rdy_q   <= rdy_d;
      ovf_q   <= ovf_d;
    end
  end

  assign bank_o  = bank_q;
  assign ready_o = rdy_q;
  assign ovf_o   = ovf_q;

  assert_bank_flips_on_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (bank_o != $past(bank_o)));
  assert_bank_still_otherwise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_evt |=> $stable(bank_o));
  assert_ready_on_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> ready_o);
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !swap_evt) |=> !ready_o);
  assert_overflow_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_evt && ready_o && !ack_i) |=> ovf_o);
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/pp_dpram.sv
module pp_dpram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              we,
  input  logic              wbank,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rbank,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_rd [2];
  logic              rsel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;
    logic              wsel;

    assign wsel = we && (wbank == 1'(b));

    always_ff @(posedge wclk) begin
      if (wsel) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) q <= '0;
      else         q <= mem[raddr];
    end

    assign bank_rd[b] = q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rsel_q <= 1'b0;
    else         rsel_q <= rbank;
  end

  assign rdata = bank_rd[rsel_q];
endmodule

// File: rtl/pingpong_cdc_buffer.sv
module pingpong_cdc_buffer #(
  parameter int   DATA_W      = 32,
  parameter int   BANK_DEPTH  = 1024,
  parameter int   SYNC_STAGES = 2,
  localparam int  ADDR_W      = $clog2(BANK_DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_done,
  output logic              wr_bank,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bank,
  output logic              rd_ready,
  output logic              rd_overflow
);
  logic wr_rst_s_n;
  logic rd_rst_s_n;

  pp_rst_sync #(.STAGES(2)) u_wr_rst (
    .clk(wr_clk), .arst_n(wr_rst_n), .rst_n_o(wr_rst_s_n));

  pp_rst_sync #(.STAGES(2)) u_rd_rst (
    .clk(rd_clk), .arst_n(rd_rst_n), .rst_n_o(rd_rst_s_n));

  pp_wr_ctrl u_wr_ctrl (
    .clk(wr_clk), .rst_n(wr_rst_s_n), .done_i(wr_done), .bank_o(wr_bank));

  pp_rd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_rd_ctrl (
    .clk(rd_clk), .rst_n(rd_rst_s_n), .wbank_async(wr_bank), .ack_i(rd_ack),
    .bank_o(rd_bank), .ready_o(rd_ready), .ovf_o(rd_overflow));

  pp_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(wr_en), .wbank(wr_bank), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rd_rst_s_n), .rbank(rd_bank), .raddr(rd_addr),
    .rdata(rd_data));
endmodule

// File: tb/pingpong_cdc_buffer_tb.sv
`timescale 1ns/1ps
module pingpong_cdc_buffer_tb_top;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam logic [DW-1:0] MASK = 32'hFFFF_0000;
  localparam logic [AW-1:0] TADDR [8] = '{10'd0, 10'd1, 10'd2, 10'd3,
                                          10'd100, 10'd511, 10'd512, 10'd1023};
  localparam logic [DW-1:0] TDATA [8] = '{32'h0000_0001, 32'hA5A5_5A5A,
                                          32'h1234_5678, 32'hFFFF_FFFF,
                                          32'h0F0F_F0F0, 32'hDEAD_BEEF,
                                          32'h8000_0001, 32'h7654_3210};

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic wr_rst_n = 1'b1, rd_rst_n = 1'b1;
  logic wr_en = 1'b0, wr_done = 1'b0, rd_ack = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_bank, rd_bank, rd_ready, rd_overflow;

  int n_cmp = 0;
  int n_mis = 0;
  bit fin = 1'b0;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  pingpong_cdc_buffer #(.DATA_W(DW), .BANK_DEPTH(1 << AW)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_done(wr_done), .wr_bank(wr_bank),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .rd_bank(rd_bank), .rd_ready(rd_ready),
    .rd_overflow(rd_overflow));

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_word(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge rd_clk);
    rd_addr = a;
    @(negedge rd_clk);
    d = rd_data;
  endtask

  task automatic ack_pulse();
    @(negedge rd_clk);
    rd_ack = 1'b1;
    @(negedge rd_clk);
    rd_ack = 1'b0;
  endtask

  task automatic swap_bank(input logic we, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, output int n);
    logic old;
    old = rd_bank;
    @(negedge wr_clk);
    wr_done = 1'b1; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge wr_clk);
    #1;
    wr_done = 1'b0; wr_en = 1'b0;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge rd_clk);
      #1;
      n++;
      if (rd_bank !== old) break;
    end
  endtask

  initial begin
    #500_000;
    if (!fin) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int n;
    #1;
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    #40;
    chk("R1 reset wr_bank", {31'd0, wr_bank}, 32'd0);
    chk("R3 reset rd_bank", {31'd0, rd_bank}, 32'd1);
    chk("R3 reset rd_ready", {31'd0, rd_ready}, 32'd0);
    chk("R3 reset rd_overflow", {31'd0, rd_overflow}, 32'd0);
    chk("R3 reset rd_data", rd_data, 32'd0);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    repeat (5) @(negedge rd_clk);

    // table walk: fill bank 0 (R1)
    for (int i = 0; i < 8; i++) wr_word(TADDR[i], TDATA[i]);
    chk("R1 wr_bank holds", {31'd0, wr_bank}, 32'd0);

    // completion with a write in the same cycle (R2), crossing (R4), ready (R5)
    swap_bank(1'b1, 10'd12, 32'hC0DE_0012, n);
    chk("R2 wr_bank flipped", {31'd0, wr_bank}, 32'd1);
    chk("R4 latency 2..4", {31'd0, (n >= 2 && n <= 4)}, 32'd1);
    chk("R4 rd_bank is completed bank", {31'd0, rd_bank}, 32'd0);
    chk("R5 ready set", {31'd0, rd_ready}, 32'd1);
    chk("R7 no overflow yet", {31'd0, rd_overflow}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      rd_word(TADDR[i], d);
      chk("R6 read table word", d, TDATA[i]);
    end
    rd_word(10'd12, d);
    chk("R2 done-cycle write in old bank", d, 32'hC0DE_0012);

    // read latency (R6)
    @(negedge rd_clk);
    rd_addr = TADDR[0];
    #1;
    chk("R6 data held before edge", rd_data, 32'hC0DE_0012);
    @(negedge rd_clk);
    chk("R6 data after one edge", rd_data, TDATA[0]);

    // writer fills its own bank; reader bank undisturbed (R8)
    for (int i = 0; i < 8; i++) wr_word(TADDR[i], TDATA[i] ^ MASK);
    for (int i = 0; i < 8; i++) begin
      rd_word(TADDR[i], d);
      chk("R8 reader bank unchanged", d, TDATA[i]);
    end

    ack_pulse();
    chk("R5 ack clears ready", {31'd0, rd_ready}, 32'd0);
    ack_pulse();
    chk("R9 idle ack keeps ready low", {31'd0, rd_ready}, 32'd0);
    chk("R9 idle ack keeps overflow", {31'd0, rd_overflow}, 32'd0);
    chk("R9 idle ack keeps bank", {31'd0, rd_bank}, 32'd0);

    // second completion: reader moves to bank 1
    swap_bank(1'b0, '0, '0, n);
    chk("R4 second latency 2..4", {31'd0, (n >= 2 && n <= 4)}, 32'd1);
    chk("R4 rd_bank now 1", {31'd0, rd_bank}, 32'd1);
    chk("R2 wr_bank back to 0", {31'd0, wr_bank}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd_word(TADDR[i], d);
      chk("R8 new bank contents", d, TDATA[i] ^ MASK);
    end

    // completion without acknowledge: overflow (R7)
    wr_word(10'd5, 32'h5EED_0005);
    swap_bank(1'b0, '0, '0, n);
    chk("R7 overflow set", {31'd0, rd_overflow}, 32'd1);
    chk("R7 newest bank handed over", {31'd0, rd_bank}, 32'd0);
    chk("R7 ready stays set", {31'd0, rd_ready}, 32'd1);
    rd_word(10'd5, d);
    chk("R7 newest data visible", d, 32'h5EED_0005);
    ack_pulse();
    chk("R5 ack after overflow clears ready", {31'd0, rd_ready}, 32'd0);
    chk("R7 overflow sticky", {31'd0, rd_overflow}, 32'd1);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule